// File: doc/BRIEF.md
# Hex Word to ASCII Byte Streamer

This block turns one 32-bit word into a line of text for a byte-wide transmitter. A one-cycle start strobe while the block is idle captures the word. The block then emits eight hexadecimal digit characters, highest nibble first, and ends the line with a newline byte. Digits 0 to 9 map to the ASCII codes 0x30 to 0x39. Values 10 to 15 map to the uppercase letters 0x41 to 0x46.

The byte output is a valid/ready stream. The block raises valid with a byte and holds that byte unchanged until ready is high in the same cycle. That cycle counts as the transfer, and the next byte (if any) appears in the following cycle. The transmitter may hold ready low for any number of cycles, and the block simply waits. The busy flag is a plain status pin. It stays high from the cycle after an accepted start until the cycle after the newline transfer. Serial bit timing belongs to the transmitter and is not part of this block.

Top module: `hex_word_tx`

## Requirements
- R1: During and right after reset, busy_o and tx_valid_o are low.
- R2: A start_i pulse while busy_o is low captures word_i at that clock edge. In the next cycle busy_o and tx_valid_o are both high.
- R3: Each accepted word produces exactly nine transfers: eight digit characters, then the newline byte 0x0A as the ninth.
- R4: The digits go out from the most significant nibble (bits 31..28) to the least significant (bits 3..0).
- R5: A nibble n in the range 0 to 9 is sent as the byte 0x30 + n.
- R6: A nibble n in the range 10 to 15 is sent as the byte 0x37 + n, which is uppercase 'A' to 'F'.
- R7: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o stays unchanged in the next cycle. A byte is taken only in a cycle where both are high.
- R8: A start_i pulse while busy_o is high is ignored. This includes the cycle in which the newline is transferred. Such a pulse adds no bytes and does not change the bytes that follow.
- R9: busy_o falls in the cycle right after the newline transfer. A start_i pulse in that cycle is accepted.
- R10: Changes on word_i after the capture edge have no effect on the bytes sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to send word_i; honoured only while idle |
| word_i | input | 32 | Value to print, sampled on an accepted start |
| busy_o | output | 1 | High while a line is being sent |
| tx_data_o | output | 8 | ASCII byte offered to the transmitter |
| tx_valid_o | output | 1 | tx_data_o holds a byte to transfer |
| tx_ready_i | input | 1 | Transmitter accepts the byte in this cycle |

## Verification
Two functions can fall in the same cycle: the transfer of the final newline, and a new start request that arrives while busy_o is still high. The bench keeps ready high so that the newline cycle is known exactly, and pulses start with a different word in that cycle. It then checks three things: busy_o is low in the next cycle, no extra bytes appear, and a start in that next cycle launches a fresh line whose bytes match the scoreboard. Separately, a random ready pattern exercises the hold rule, and start pulses in the middle of a line check that they are ignored.

// File: rtl/hexw_pkg.sv
package hexw_pkg;
  localparam int unsigned CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;

  localparam char_t NEWLINE_CHAR = 8'h0A;
  localparam char_t DIGIT_BASE   = 8'h30;
  localparam char_t LETTER_BASE  = 8'h37;
  localparam int unsigned FIRST_LETTER = 10;
endpackage

// File: rtl/hexw_nib2ascii.sv
module hexw_nib2ascii
  import hexw_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic [NIB_W-1:0] nib_i,
  output char_t            char_o
);
  logic is_letter;

  always_comb begin
    is_letter = (nib_i >= NIB_W'(FIRST_LETTER));
    if (is_letter) char_o = LETTER_BASE + CHAR_W'(nib_i);
    else           char_o = DIGIT_BASE  + CHAR_W'(nib_i);
  end
endmodule

// File: rtl/hexw_word_shreg.sv
module hexw_word_shreg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              shift_i,
  output logic [NIB_W-1:0]  nib_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= word_i;
    end else if (shift_i) begin
      sr_q <= {sr_q[DATA_W-NIB_W-1:0], {NIB_W{1'b0}}};
    end
  end

  assign nib_o = sr_q[DATA_W-1 -: NIB_W];
endmodule

// File: rtl/hexw_seq.sv
module hexw_seq #(
  parameter int unsigned DIGITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ready_i,
  output logic busy_o,
  output logic load_o,
  output logic shift_o,
  output logic tail_o
);
  localparam int unsigned CNT_W = $clog2(DIGITS + 1);

  logic             busy_q;
  logic [CNT_W-1:0] pos_q;
  logic             fire;

  assign load_o  = start_i && !busy_q;
  assign fire    = busy_q && ready_i;
  assign tail_o  = (pos_q == CNT_W'(DIGITS));
  assign shift_o = fire && !tail_o;
  assign busy_o  = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
    end else if (fire) begin
      if (tail_o) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        pos_q  <= pos_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hex_word_tx.sv
module hex_word_tx
  import hexw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              busy_o,
  output logic [CHAR_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  localparam int unsigned DIGITS = DATA_W / NIB_W;

  logic             load;
  logic             shift;
  logic             tail;
  logic [NIB_W-1:0] nib;
  char_t            digit_char;

  hexw_seq #(.DIGITS(DIGITS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_i (tx_ready_i),
    .busy_o  (busy_o),
    .load_o  (load),
    .shift_o (shift),
    .tail_o  (tail)
  );

  hexw_word_shreg #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .word_i  (word_i),
    .shift_i (shift),
    .nib_o   (nib)
  );

  hexw_nib2ascii #(.NIB_W(NIB_W)) u_enc (
    .nib_i  (nib),
    .char_o (digit_char)
  );

  assign tx_valid_o = busy_o;
  assign tx_data_o  = tail ? NEWLINE_CHAR : digit_char;
endmodule

// File: rtl/hexw_tx_checker.sv
module hexw_tx_checker #(
  parameter int unsigned DIGITS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i
);
  localparam int unsigned CW = $clog2(DIGITS + 1);
  logic [CW-1:0] seen_q;
  logic          xfer;

  assign xfer = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (xfer) seen_q <= (seen_q == CW'(DIGITS)) ? '0 : seen_q + CW'(1);
  end

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && tx_valid_o));

  p_newline_ninth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> ((seen_q == CW'(DIGITS)) == (tx_data_o == 8'h0A)));

  p_charset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (tx_data_o == 8'h0A
                    || (tx_data_o >= 8'h30 && tx_data_o <= 8'h39)
                    || (tx_data_o >= 8'h41 && tx_data_o <= 8'h46)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(xfer && tx_data_o == 8'h0A)) |=> busy_o);

  p_drop_after_nl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && tx_data_o == 8'h0A) |=> !busy_o);
endmodule

bind hex_word_tx hexw_tx_checker #(.DIGITS(DIGITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i)
);

// File: tb/hex_word_tx_bench.sv
`timescale 1ns/1ps
module hex_word_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        busy_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  bit rdy_random = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [7:0] exp_q[$];
  bit   hold_pend = 1'b0;
  logic [7:0] hold_data = '0;

  always #4 clk = ~clk;

  hex_word_tx u_hex_word_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .busy_o(busy_o), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i)
  );

  function automatic logic [7:0] exp_char(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: called at a negedge; waits for idle, pushes expected bytes.
  task automatic send_word(input logic [31:0] w);
    while (busy_o) @(negedge clk);
    start_i = 1'b1;
    word_i  = w;
    for (int k = 7; k >= 0; k--) exp_q.push_back(exp_char(w[k*4 +: 4]));
    exp_q.push_back(8'h0A);
    @(negedge clk);
    start_i = 1'b0;
    word_i  = ~w;  // R10: later input changes must not matter
    check(busy_o && tx_valid_o, "R2 launch busy/valid", {busy_o, tx_valid_o}, 2'b11);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy_o) @(negedge clk);
  endtask

  // Monitor / ready driver / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rdy_random) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready_i = lfsr[0] & lfsr[2];
      end else begin
        tx_ready_i = 1'b1;
      end
      #1;
      if (rst_n) begin
        if (hold_pend) begin
          check(tx_valid_o && tx_data_o == hold_data, "R7 hold while not ready",
                {tx_valid_o, tx_data_o}, {1'b1, hold_data});
          hold_pend = 1'b0;
        end
        if (tx_valid_o && tx_ready_i) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected byte", tx_data_o, 0);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(tx_data_o == e, "R3/R4/R5/R6/R10 byte", tx_data_o, e);
          end
        end else if (tx_valid_o) begin
          hold_pend = 1'b1;
          hold_data = tx_data_o;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !tx_valid_o, "R1 reset state", {busy_o, tx_valid_o}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !tx_valid_o, "R1 after reset", {busy_o, tx_valid_o}, 2'b00);

    // R4 R5 R6 with steady ready
    rdy_random = 1'b0;
    send_word(32'h0123ABCD);
    drain();
    send_word(32'h9A5F09AF);
    drain();

    // R7 with random back-pressure, R8 start mid-line ignored
    rdy_random = 1'b1;
    send_word(32'hDEADBEEF);
    repeat (3) @(negedge clk);
    start_i = 1'b1; word_i = 32'h11111111;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    check(!tx_valid_o && exp_q.size() == 0, "R8 no bytes from ignored start",
          tx_valid_o, 0);
    send_word(32'hFFFFFFFF);
    drain();
    send_word(32'h00000000);
    drain();

    // R8/R9: start in the newline cycle, then restart right after
    rdy_random = 1'b0;
    send_word(32'h76543210);
    repeat (8) @(negedge clk);
    check(tx_valid_o && tx_data_o == 8'h0A, "R3 newline cycle", tx_data_o, 8'h0A);
    start_i = 1'b1; word_i = 32'h55555555;
    @(negedge clk);
    start_i = 1'b0;
    check(!busy_o && !tx_valid_o, "R9 busy low after newline / R8 start ignored",
          {busy_o, tx_valid_o}, 2'b00);
    send_word(32'hC0FFEE42);
    drain();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !busy_o, "R3 scoreboard empty", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule